// File: doc/BRIEF.md
# Banked Register File with Per-Bank Port Arbitration

This block holds a 64-entry, 32-bit physical register file cut into 8 banks of 8 rows. Each bank has only two local read ports and two local write ports. A 4-wide issue group presents eight source operands and four destination writes to it in every cycle. The group has already been issued speculatively, so the block sorts the requests by bank and hands out the scarce local ports. It then steers each granted operand's row address onto a local port and returns that port's data on the operand's own global read output.

Ports are handed out in a fixed priority order. When operands name the same physical register, they take a single local port between them, and that port feeds every one of their global outputs. An operand flagged as bypassed from the previous cycle takes no port. An instruction that cannot get every port it needs is reported on a per-slot kill vector in the same cycle, so the pipeline can squash it and issue it again. A killed instruction neither writes nor receives read data.

Top module: `rfb_top`

## Requirements
- R1: After reset every register reads as zero, and `rd_vld` and every `rd_data` lane are zero.
- R2: A register number splits into bank = bits [2:0] and row = bits [5:3]. Operand lane k belongs to slot k/2, with k even for the first source. A granted lane shows `rd_vld`=1 and the register's value one clock after the request.
- R3: Each bank serves at most 2 distinct registers per cycle. Operands are served in ascending lane order, and an operand that needs a third distinct register in its bank loses.
- R4: An operand naming a register that an earlier operand already holds a port for shares that port and never loses.
- R5: An operand makes no request, takes no port and can cause no kill when its `op_byp` bit is 1, when its `op_en` bit is 0, or when its slot's `iss_vld` bit is 0.
- R6: `kill[s]` is high in the request cycle when any requesting operand of slot s lost, or when its write lost. A killed slot's lanes show `rd_vld`=0 and data zero on the next clock.
- R7: A write is requested by slots with `iss_vld`, `wr_en` and no read loss. The first 2 in slot order per bank are performed; a later one is killed and leaves the register unchanged.
- R8: If two performed writes in one cycle name the same register, the higher slot's data is kept. A read in the same cycle as a write returns the old value.
- R9: A lane without `rd_vld` shows zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 4 | Slot holds an issued instruction |
| op_en | input | 8 | Source operand lane is used |
| op_byp | input | 8 | Source lane is bypassed from the previous cycle |
| op_reg | input | 8x6 | Source register number per lane |
| wr_en | input | 4 | Slot writes a destination |
| wr_reg | input | 4x6 | Destination register per slot |
| wr_data | input | 4x32 | Destination data per slot |
| kill | output | 4 | Slot lost arbitration this cycle |
| rd_vld | output | 8 | Registered read lane valid |
| rd_data | output | 8x32 | Registered read data per lane |

## Verification
A wrong port choice in a bank arbiter shows up in the same cycle as a wrong `kill` bit. On the next clock it shows as wrong data on a lane, because the lane is steered to the other local port. A missed or extra write inside a bank stays hidden until that register is read, so the bench keeps a shadow copy of the file and compares every later read against it. Random cycles draw registers from a small pool so that sharing, three-way contention and colliding writes happen often.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
    localparam int unsigned RFB_REGS     = 64;
    localparam int unsigned RFB_DATA_W   = 32;
    localparam int unsigned RFB_BANKS    = 8;
    localparam int unsigned RFB_RD_PORTS = 2;
    localparam int unsigned RFB_WR_PORTS = 2;
    localparam int unsigned RFB_ISSUE_W  = 4;

    // width of a selector over n items, never zero
    function automatic int unsigned sel_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rfb_rd_arb.sv
module rfb_rd_arb #(
    parameter int unsigned NUM_OPS  = 8,
    parameter int unsigned ROW_W    = 3,
    parameter int unsigned RD_PORTS = 2,
    parameter int unsigned RSEL_W   = 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_OPS-1:0]                 req,
    input  logic [NUM_OPS-1:0][ROW_W-1:0]      row,
    output logic [RD_PORTS-1:0]                port_vld,
    output logic [RD_PORTS-1:0][ROW_W-1:0]     port_row,
    output logic [NUM_OPS-1:0][RSEL_W-1:0]     op_sel,
    output logic [NUM_OPS-1:0]                 op_lose
);
    logic [RD_PORTS-1:0]            v_vld;
    logic [RD_PORTS-1:0][ROW_W-1:0] v_row;
    logic [NUM_OPS-1:0][RSEL_W-1:0] v_sel;
    logic [NUM_OPS-1:0]             v_lose;
    logic                           placed;

    // single pass in priority order: share a held row, else take the next free port
    always_comb begin
        v_vld  = '0;
        v_row  = '0;
        v_sel  = '0;
        v_lose = '0;
        placed = 1'b0;
        for (int k = 0; k < NUM_OPS; k++) begin
            placed = 1'b0;
            if (req[k]) begin
                for (int p = 0; p < RD_PORTS; p++) begin
                    if (!placed && v_vld[p] && (v_row[p] == row[k])) begin
                        placed   = 1'b1;
                        v_sel[k] = RSEL_W'(p);
                    end
                end
                for (int p = 0; p < RD_PORTS; p++) begin
                    if (!placed && !v_vld[p]) begin
                        placed   = 1'b1;
                        v_vld[p] = 1'b1;
                        v_row[p] = row[k];
                        v_sel[k] = RSEL_W'(p);
                    end
                end
                v_lose[k] = !placed;
            end
        end
    end

    assign port_vld = v_vld;
    assign port_row = v_row;
    assign op_sel   = v_sel;
    assign op_lose  = v_lose;

    AST_RD_LOSS_MEANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (|op_lose) |-> (&port_vld)); // R3
    AST_RD_LOSS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_lose & ~req) == '0); // R5

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_pa
        for (genvar q = p + 1; q < RD_PORTS; q++) begin : g_pb
            AST_RD_ROWS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
                (port_vld[p] && port_vld[q]) |-> (port_row[p] != port_row[q])); // R4
        end
    end
endmodule

// File: rtl/rfb_wr_arb.sv
module rfb_wr_arb #(
    parameter int unsigned ISSUE_W  = 4,
    parameter int unsigned ROW_W    = 3,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WR_PORTS = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ISSUE_W-1:0]                 req,
    input  logic [ISSUE_W-1:0][ROW_W-1:0]      row,
    input  logic [ISSUE_W-1:0][DATA_W-1:0]     data,
    output logic [WR_PORTS-1:0]                port_vld,
    output logic [WR_PORTS-1:0][ROW_W-1:0]     port_row,
    output logic [WR_PORTS-1:0][DATA_W-1:0]    port_data,
    output logic [ISSUE_W-1:0]                 slot_lose
);
    logic [WR_PORTS-1:0]             v_vld;
    logic [WR_PORTS-1:0][ROW_W-1:0]  v_row;
    logic [WR_PORTS-1:0][DATA_W-1:0] v_data;
    logic [ISSUE_W-1:0]              v_lose;
    logic                            placed;

    // ports fill in slot order, so a later port always carries a higher slot
    always_comb begin
        v_vld  = '0;
        v_row  = '0;
        v_data = '0;
        v_lose = '0;
        placed = 1'b0;
        for (int s = 0; s < ISSUE_W; s++) begin
            placed = 1'b0;
            if (req[s]) begin
                for (int p = 0; p < WR_PORTS; p++) begin
                    if (!placed && !v_vld[p]) begin
                        placed    = 1'b1;
                        v_vld[p]  = 1'b1;
                        v_row[p]  = row[s];
                        v_data[p] = data[s];
                    end
                end
                v_lose[s] = !placed;
            end
        end
    end

    assign port_vld  = v_vld;
    assign port_row  = v_row;
    assign port_data = v_data;
    assign slot_lose = v_lose;

    AST_WR_LOSS_MEANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_lose) |-> (&port_vld)); // R7
    AST_WR_LOSS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_lose & ~req) == '0); // R7
endmodule

// File: rtl/rfb_bank.sv
module rfb_bank #(
    parameter int unsigned ROWS     = 8,
    parameter int unsigned ROW_W    = 3,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned RD_PORTS = 2,
    parameter int unsigned WR_PORTS = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [RD_PORTS-1:0]                rd_en,
    input  logic [RD_PORTS-1:0][ROW_W-1:0]     rd_row,
    output logic [RD_PORTS-1:0][DATA_W-1:0]    rd_data,
    input  logic [WR_PORTS-1:0]                wr_vld,
    input  logic [WR_PORTS-1:0][ROW_W-1:0]     wr_row,
    input  logic [WR_PORTS-1:0][DATA_W-1:0]    wr_data
);
    typedef struct packed {
        logic [ROWS-1:0][DATA_W-1:0] mem;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        for (int p = 0; p < RD_PORTS; p++) begin
            rd_data[p] = rd_en[p] ? st_q.mem[rd_row[p]] : '0;
        end
    end

    // later ports apply last, so the higher slot wins a row collision
    always_comb begin
        st_d = st_q;
        for (int p = 0; p < WR_PORTS; p++) begin
            if (wr_vld[p]) begin
                st_d.mem[wr_row[p]] = wr_data[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BANK_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|wr_vld) |=> $stable(st_q)); // R7
endmodule

// File: rtl/rfb_top.sv
module rfb_top
    import rfb_pkg::*;
#(
    parameter int unsigned REGS     = RFB_REGS,
    parameter int unsigned DATA_W   = RFB_DATA_W,
    parameter int unsigned BANKS    = RFB_BANKS,
    parameter int unsigned RD_PORTS = RFB_RD_PORTS,
    parameter int unsigned WR_PORTS = RFB_WR_PORTS,
    parameter int unsigned ISSUE_W  = RFB_ISSUE_W,
    localparam int unsigned SRCS    = 2,
    localparam int unsigned NUM_OPS = ISSUE_W * SRCS,
    localparam int unsigned ADDR_W  = $clog2(REGS),
    localparam int unsigned BANK_W  = $clog2(BANKS),
    localparam int unsigned ROWS    = REGS / BANKS,
    localparam int unsigned ROW_W   = ADDR_W - BANK_W,
    localparam int unsigned RSEL_W  = sel_w(RD_PORTS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ISSUE_W-1:0]                iss_vld,
    input  logic [NUM_OPS-1:0]                op_en,
    input  logic [NUM_OPS-1:0]                op_byp,
    input  logic [NUM_OPS-1:0][ADDR_W-1:0]    op_reg,
    input  logic [ISSUE_W-1:0]                wr_en,
    input  logic [ISSUE_W-1:0][ADDR_W-1:0]    wr_reg,
    input  logic [ISSUE_W-1:0][DATA_W-1:0]    wr_data,
    output logic [ISSUE_W-1:0]                kill,
    output logic [NUM_OPS-1:0]                rd_vld,
    output logic [NUM_OPS-1:0][DATA_W-1:0]    rd_data
);
    typedef struct packed {
        logic [NUM_OPS-1:0]             vld;
        logic [NUM_OPS-1:0][DATA_W-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [NUM_OPS-1:0]              op_req;
    logic [NUM_OPS-1:0][BANK_W-1:0]  op_bank;
    logic [NUM_OPS-1:0][ROW_W-1:0]   op_row;
    logic [ISSUE_W-1:0][BANK_W-1:0]  wr_bank;
    logic [ISSUE_W-1:0][ROW_W-1:0]   wr_row;
    logic [ISSUE_W-1:0]              wr_req;
    logic [ISSUE_W-1:0]              rd_kill;
    logic [NUM_OPS-1:0]              rd_lose_all;
    logic [ISSUE_W-1:0]              wr_lose_all;

    logic [BANKS-1:0][NUM_OPS-1:0]                rd_lose_b;
    logic [BANKS-1:0][NUM_OPS-1:0][RSEL_W-1:0]    rd_sel_b;
    logic [BANKS-1:0][RD_PORTS-1:0][DATA_W-1:0]   bank_rdata;
    logic [BANKS-1:0][ISSUE_W-1:0]                wr_lose_b;

    // operand decode: low bits pick the bank, high bits the row
    always_comb begin
        for (int k = 0; k < NUM_OPS; k++) begin
            op_req[k]  = iss_vld[k / SRCS] && op_en[k] && !op_byp[k];
            op_bank[k] = op_reg[k][BANK_W-1:0];
            op_row[k]  = op_reg[k][ADDR_W-1:BANK_W];
        end
        for (int s = 0; s < ISSUE_W; s++) begin
            wr_bank[s] = wr_reg[s][BANK_W-1:0];
            wr_row[s]  = wr_reg[s][ADDR_W-1:BANK_W];
        end
    end

    // read losses collapse to slots; only read survivors compete for writes
    always_comb begin
        rd_lose_all = '0;
        for (int b = 0; b < BANKS; b++) begin
            rd_lose_all = rd_lose_all | rd_lose_b[b];
        end
        for (int s = 0; s < ISSUE_W; s++) begin
            rd_kill[s] = |rd_lose_all[s*SRCS +: SRCS];
            wr_req[s]  = iss_vld[s] && wr_en[s] && !rd_kill[s];
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [NUM_OPS-1:0]              rq;
        logic [ISSUE_W-1:0]              wq;
        logic [RD_PORTS-1:0]             rp_vld;
        logic [RD_PORTS-1:0][ROW_W-1:0]  rp_row;
        logic [WR_PORTS-1:0]             wp_vld;
        logic [WR_PORTS-1:0][ROW_W-1:0]  wp_row;
        logic [WR_PORTS-1:0][DATA_W-1:0] wp_data;

        always_comb begin
            for (int k = 0; k < NUM_OPS; k++) begin
                rq[k] = op_req[k] && (op_bank[k] == BANK_W'(b));
            end
            for (int s = 0; s < ISSUE_W; s++) begin
                wq[s] = wr_req[s] && (wr_bank[s] == BANK_W'(b));
            end
        end

        rfb_rd_arb #(
            .NUM_OPS (NUM_OPS),
            .ROW_W   (ROW_W),
            .RD_PORTS(RD_PORTS),
            .RSEL_W  (RSEL_W)
        ) u_rd_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (rq),
            .row     (op_row),
            .port_vld(rp_vld),
            .port_row(rp_row),
            .op_sel  (rd_sel_b[b]),
            .op_lose (rd_lose_b[b])
        );

        rfb_wr_arb #(
            .ISSUE_W (ISSUE_W),
            .ROW_W   (ROW_W),
            .DATA_W  (DATA_W),
            .WR_PORTS(WR_PORTS)
        ) u_wr_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (wq),
            .row      (wr_row),
            .data     (wr_data),
            .port_vld (wp_vld),
            .port_row (wp_row),
            .port_data(wp_data),
            .slot_lose(wr_lose_b[b])
        );

        rfb_bank #(
            .ROWS    (ROWS),
            .ROW_W   (ROW_W),
            .DATA_W  (DATA_W),
            .RD_PORTS(RD_PORTS),
            .WR_PORTS(WR_PORTS)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (rp_vld),
            .rd_row (rp_row),
            .rd_data(bank_rdata[b]),
            .wr_vld (wp_vld),
            .wr_row (wp_row),
            .wr_data(wp_data)
        );
    end

    // next-state: steer each surviving lane to its bank's local port
    always_comb begin
        wr_lose_all = '0;
        for (int b = 0; b < BANKS; b++) begin
            wr_lose_all = wr_lose_all | wr_lose_b[b];
        end
        kill = rd_kill | wr_lose_all;
        st_d = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            st_d.vld[k] = op_req[k] && !rd_lose_all[k] && !kill[k / SRCS];
            if (st_d.vld[k]) begin
                st_d.data[k] = bank_rdata[op_bank[k]][rd_sel_b[op_bank[k]][k]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vld  = st_q.vld;
    assign rd_data = st_q.data;

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot_chk
        AST_KILLED_SLOT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            kill[s] |=> (rd_vld[s*SRCS +: SRCS] == '0)); // R6
        AST_IDLE_SLOT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            !iss_vld[s] |=> (rd_vld[s*SRCS +: SRCS] == '0)); // R5
        AST_NO_REQ_NO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
            (((op_en[s*SRCS +: SRCS] & ~op_byp[s*SRCS +: SRCS]) == '0) && !wr_en[s])
            |-> !kill[s]); // R5
    end

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_lane_chk
        AST_LANE_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_vld[k] |-> (rd_data[k] == '0)); // R9
    end
endmodule

// File: tb/sim_rfb_top.sv
module sim_rfb_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic [3:0]        iss_vld;
    logic [7:0]        op_en, op_byp;
    logic [7:0][5:0]   op_reg;
    logic [3:0]        wr_en;
    logic [3:0][5:0]   wr_reg;
    logic [3:0][31:0]  wr_data;
    logic [3:0]        kill;
    logic [7:0]        rd_vld;
    logic [7:0][31:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] shadow [64];

    always #(CLK_P/2) clk = ~clk;

    rfb_top u0 (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .op_en(op_en), .op_byp(op_byp),
        .op_reg(op_reg), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
        .kill(kill), .rd_vld(rd_vld), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        iss_vld = '0; op_en = '0; op_byp = '0; op_reg = '0;
        wr_en = '0; wr_reg = '0; wr_data = '0;
    endtask

    // reference: per-bank port counts, written from the requirement text
    task automatic model(output logic [3:0] ek, output logic [7:0] ev, output logic [7:0][31:0] ed);
        int          used [8];
        int          wcnt [8];
        logic [5:0]  held [8][2];
        logic [7:0]  req, lose;
        logic [3:0]  rk, wreq, wlose;
        for (int b = 0; b < 8; b++) begin used[b] = 0; wcnt[b] = 0; end
        lose = '0; wlose = '0;
        for (int k = 0; k < 8; k++) begin
            req[k] = iss_vld[k/2] && op_en[k] && !op_byp[k];
            if (req[k]) begin
                int b = int'(op_reg[k][2:0]);
                bit shared = 0;
                for (int i = 0; i < used[b]; i++) if (held[b][i] == op_reg[k]) shared = 1;
                if (!shared) begin
                    if (used[b] < 2) begin held[b][used[b]] = op_reg[k]; used[b]++; end
                    else lose[k] = 1'b1;
                end
            end
        end
        for (int s = 0; s < 4; s++) begin
            rk[s] = lose[2*s] | lose[2*s+1];
            wreq[s] = iss_vld[s] && wr_en[s] && !rk[s];
            if (wreq[s]) begin
                int b = int'(wr_reg[s][2:0]);
                if (wcnt[b] < 2) wcnt[b]++;
                else wlose[s] = 1'b1;
            end
        end
        ek = rk | wlose;
        for (int k = 0; k < 8; k++) begin
            ev[k] = req[k] && !lose[k] && !ek[k/2];
            ed[k] = ev[k] ? shadow[op_reg[k]] : 32'h0;
        end
        for (int s = 0; s < 4; s++) begin
            if (wreq[s] && !wlose[s]) shadow[wr_reg[s]] = wr_data[s];
        end
    endtask

    // inputs set at the falling edge; kill is checked before the rising edge, lanes after it
    task automatic run_cycle(input string tag);
        logic [3:0] ek; logic [7:0] ev; logic [7:0][31:0] ed;
        model(ek, ev, ed);
        #1;
        chk(tag, "kill", 32'(kill), 32'(ek));
        @(posedge clk);
        @(negedge clk);
        chk(tag, "rd_vld", 32'(rd_vld), 32'(ev));
        for (int k = 0; k < 8; k++) chk(tag, $sformatf("rd_data[%0d]", k), rd_data[k], ed[k]);
        clear_in();
    endtask

    task automatic read_reg(input int lane, input logic [5:0] r);
        iss_vld[lane/2] = 1'b1; op_en[lane] = 1'b1; op_reg[lane] = r;
    endtask

    task automatic write_reg(input int s, input logic [5:0] r, input logic [31:0] d);
        iss_vld[s] = 1'b1; wr_en[s] = 1'b1; wr_reg[s] = r; wr_data[s] = d;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog R1..: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] pool [12];
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) shadow[i] = '0;
        clear_in();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports, then every register reads zero
        chk("R1", "rd_vld", 32'(rd_vld), 32'h0);
        chk("R1", "rd_data[0]", rd_data[0], 32'h0);
        chk("R1", "kill", 32'(kill), 32'h0);
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 8; k++) read_reg(k, 6'(c*8 + k));
            run_cycle("R1");
        end

        // R2: write two rows of bank 1, read back on chosen lanes
        write_reg(0, 6'd9, 32'hA5A5_0009);
        write_reg(1, 6'd17, 32'h1234_0017);
        run_cycle("R2");
        read_reg(3, 6'd17); read_reg(6, 6'd9);
        run_cycle("R2");

        // R3: three distinct rows of bank 1; lane 2 loses, slot 1 killed
        read_reg(0, 6'd1); read_reg(1, 6'd9); read_reg(2, 6'd17); read_reg(3, 6'd2);
        run_cycle("R3");

        // R4: repeated register shares a port, no kill
        read_reg(0, 6'd9); read_reg(1, 6'd17); read_reg(2, 6'd9);
        read_reg(3, 6'd17); read_reg(5, 6'd9); read_reg(7, 6'd17);
        run_cycle("R4");

        // R5: lane 2 bypassed frees the port; disabled lane 3 ignored
        read_reg(0, 6'd1); read_reg(1, 6'd9); read_reg(2, 6'd17); op_byp[2] = 1'b1;
        iss_vld[1] = 1'b1; op_reg[3] = 6'd25;
        op_reg[4] = 6'd33; op_en[4] = 1'b1;
        run_cycle("R5");

        // R7: three writes to bank 2; slot 2 killed and its register unchanged
        write_reg(0, 6'd2, 32'h0000_0202);
        write_reg(1, 6'd10, 32'h0000_1010);
        write_reg(2, 6'd18, 32'hDEAD_0018);
        run_cycle("R7");
        read_reg(0, 6'd18); read_reg(1, 6'd10);
        run_cycle("R7");

        // R8: same register from slots 0 and 3, read in the same cycle sees old value
        write_reg(0, 6'd5, 32'h1111_1111);
        write_reg(3, 6'd5, 32'h3333_3333);
        read_reg(2, 6'd5);
        run_cycle("R8");
        read_reg(0, 6'd5);
        run_cycle("R8");

        // R6: read-killed slot also writes; write suppressed, lanes zero
        read_reg(0, 6'd3); read_reg(1, 6'd11); read_reg(2, 6'd19);
        write_reg(1, 6'd4, 32'hBAD0_0004);
        run_cycle("R6");
        read_reg(0, 6'd4);
        run_cycle("R6");

        // R9: lanes with op_en low stay zero while neighbours read
        read_reg(0, 6'd9); iss_vld[2] = 1'b1; op_reg[5] = 6'd9;
        run_cycle("R9");

        for (int i = 0; i < 12; i++) pool[i] = 6'($urandom_range(0, 63));
        for (int n = 0; n < 600; n++) begin
            for (int s = 0; s < 4; s++) begin
                iss_vld[s] = ($urandom_range(0, 9) < 8);
                wr_en[s]   = $urandom_range(0, 1) == 1;
                wr_reg[s]  = ($urandom_range(0, 1) == 1) ? pool[$urandom_range(0, 11)] : 6'($urandom_range(0, 63));
                wr_data[s] = $urandom;
            end
            for (int k = 0; k < 8; k++) begin
                op_en[k]  = ($urandom_range(0, 9) < 8);
                op_byp[k] = ($urandom_range(0, 9) < 2);
                op_reg[k] = ($urandom_range(0, 2) != 0) ? pool[$urandom_range(0, 11)] : 6'($urandom_range(0, 63));
            end
            run_cycle("R2/R3/R4/R6/R7");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule